// File: doc/BRIEF.md
# Pipeline hazard and forwarding control

This block holds the control side of a five-stage in-order scalar pipeline (fetch, decode, execute, memory, writeback) that also has a four-stage pipelined multiplier next to its execute and memory stages. It looks only at register specifiers and opcode classes. These come from the fetch/decode, decode/execute, execute/memory and memory/writeback latches, plus the destination fields of the three multiplier latches. From them it computes bypass mux selects and the pipeline advance controls.

The bypass selects choose between the execute/memory result, the memory/writeback value and the register file for both ALU operands. A separate select forwards a store's data operand from writeback into the memory stage. The advance controls are the PC and fetch/decode write enables, a bubble request for the decode/execute latch, and a flush of the fetch/decode latch. A stall freezes PC and fetch/decode and inserts a bubble, and the condition is evaluated again each cycle. A taken branch resolved in execute flushes both younger instructions and wins over any stall. The block is purely combinational. Decode is assumed to zero any source field that an instruction does not read.

Top module: `hazard_ctl`

## Requirements
- R1: Operand A select `fwd_a` is 0 when `dx_rs1` equals the execute/memory destination of a register-writing instruction. Otherwise it is 1 when it equals the memory/writeback destination of a register-writing instruction. Otherwise it is 2, the register file.
- R2: Operand B select `fwd_b` follows the same encoding and priority as R1, applied to `dx_rs2`.
- R3: Opcode classes are NOP=0, ALU=1, LOAD=2, STORE=3, BRANCH=4, MUL=5. Only ALU, LOAD and MUL with a nonzero destination count as producers. Register 0 and non-writing classes never cause a forward or a stall.
- R4: A load in decode/execute stalls the pipeline when its destination equals `fd_rs1`. It also stalls when its destination equals `fd_rs2` and the fetch/decode instruction is not a store. A stall drives `pc_we`=0, `fd_we`=0, `dx_bubble`=1 and `fd_flush`=0.
- R5: `fwd_sd` is 1 exactly when the execute/memory instruction is a store whose data source `xm_rs2` equals the destination of a register-writing memory/writeback instruction.
- R6: A multiply in decode/execute stalls any fetch/decode instruction that reads its destination through either source, including a store's data source.
- R7: A stall occurs when either fetch/decode source equals a nonzero destination in any of the three multiplier latches.
- R8: A register-writing fetch/decode instruction that is not a multiply stalls while the first multiplier latch holds a nonzero destination.
- R9: A register-writing fetch/decode instruction stalls when its destination equals that of a multiply in decode/execute.
- R10: When `br_taken` is 1, the outputs are `fd_flush`=1, `dx_bubble`=1, `pc_we`=1 and `fd_we`=1, whatever stall condition is present.
- R11: With no hazard and no branch, the outputs are `pc_we`=1, `fd_we`=1, `fd_flush`=0 and `dx_bubble`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fd_op | input | OPW | opcode class in fetch/decode |
| fd_rs1 | input | RW | source 1 in fetch/decode |
| fd_rs2 | input | RW | source 2 in fetch/decode |
| fd_rd | input | RW | destination in fetch/decode |
| dx_op | input | OPW | opcode class in decode/execute |
| dx_rs1 | input | RW | source 1 in decode/execute |
| dx_rs2 | input | RW | source 2 in decode/execute |
| dx_rd | input | RW | destination in decode/execute |
| xm_op | input | OPW | opcode class in execute/memory |
| xm_rs2 | input | RW | store data source in execute/memory |
| xm_rd | input | RW | destination in execute/memory |
| mw_op | input | OPW | opcode class in memory/writeback |
| mw_rd | input | RW | destination in memory/writeback |
| m1_rd | input | RW | destination in first multiplier latch (0 = empty) |
| m2_rd | input | RW | destination in second multiplier latch |
| m3_rd | input | RW | destination in third multiplier latch |
| br_taken | input | 1 | branch in execute redirects fetch |
| fwd_a | output | 2 | operand A select |
| fwd_b | output | 2 | operand B select |
| fwd_sd | output | 1 | forward writeback value to store data |
| pc_we | output | 1 | PC write enable |
| fd_we | output | 1 | fetch/decode latch write enable |
| fd_flush | output | 1 | replace fetch/decode contents with NOP |
| dx_bubble | output | 1 | load NOP into decode/execute |

## Verification
A stall and a branch flush can be requested in the same cycle. The bench provokes this by placing a load-use pair in the decode stages while raising `br_taken`, and it requires the full flush pattern with the stall suppressed. Forwarding selects and a stall can also coincide. The bench checks that a stall leaves the bypass selects computed for the decode/execute instruction unchanged, because that instruction still proceeds.

// File: rtl/hazard_ctl.sv
`timescale 1ns/1ps
module hazard_ctl #(
  parameter int RW  = 5,
  parameter int OPW = 3
) (
  input  logic [OPW-1:0] fd_op,
  input  logic [RW-1:0]  fd_rs1,
  input  logic [RW-1:0]  fd_rs2,
  input  logic [RW-1:0]  fd_rd,
  input  logic [OPW-1:0] dx_op,
  input  logic [RW-1:0]  dx_rs1,
  input  logic [RW-1:0]  dx_rs2,
  input  logic [RW-1:0]  dx_rd,
  input  logic [OPW-1:0] xm_op,
  input  logic [RW-1:0]  xm_rs2,
  input  logic [RW-1:0]  xm_rd,
  input  logic [OPW-1:0] mw_op,
  input  logic [RW-1:0]  mw_rd,
  input  logic [RW-1:0]  m1_rd,
  input  logic [RW-1:0]  m2_rd,
  input  logic [RW-1:0]  m3_rd,
  input  logic           br_taken,
  output logic [1:0]     fwd_a,
  output logic [1:0]     fwd_b,
  output logic           fwd_sd,
  output logic           pc_we,
  output logic           fd_we,
  output logic           fd_flush,
  output logic           dx_bubble
);
  localparam logic [OPW-1:0] OP_ALU = OPW'(1);
  localparam logic [OPW-1:0] OP_LD  = OPW'(2);
  localparam logic [OPW-1:0] OP_ST  = OPW'(3);
  localparam logic [OPW-1:0] OP_MUL = OPW'(5);
  localparam logic [1:0] SEL_XM = 2'd0;
  localparam logic [1:0] SEL_MW = 2'd1;
  localparam logic [1:0] SEL_RF = 2'd2;

  function automatic logic writes(input logic [OPW-1:0] op, input logic [RW-1:0] rd);
    return (rd != '0) && (op == OP_ALU || op == OP_LD || op == OP_MUL);
  endfunction

  function automatic logic reads(input logic [RW-1:0] rd, input logic [RW-1:0] s1,
                                 input logic [RW-1:0] s2);
    return (rd != '0) && (s1 == rd || s2 == rd);
  endfunction

  logic xm_wr, mw_wr, fd_wr, dx_mul;
  logic ld_use, mul_use, mpipe_use, port_clash, waw, stall, hold;

  assign xm_wr  = writes(xm_op, xm_rd);
  assign mw_wr  = writes(mw_op, mw_rd);
  assign fd_wr  = writes(fd_op, fd_rd);
  assign dx_mul = (dx_op == OP_MUL) && (dx_rd != '0);

  assign fwd_a = (xm_wr && dx_rs1 == xm_rd) ? SEL_XM :
                 (mw_wr && dx_rs1 == mw_rd) ? SEL_MW : SEL_RF;
  assign fwd_b = (xm_wr && dx_rs2 == xm_rd) ? SEL_XM :
                 (mw_wr && dx_rs2 == mw_rd) ? SEL_MW : SEL_RF;

  assign fwd_sd = (xm_op == OP_ST) && mw_wr && (xm_rs2 == mw_rd);

  assign ld_use = (dx_op == OP_LD) && (dx_rd != '0) &&
                  ((fd_rs1 == dx_rd) || ((fd_rs2 == dx_rd) && (fd_op != OP_ST)));
  assign mul_use    = dx_mul && reads(dx_rd, fd_rs1, fd_rs2);
  assign mpipe_use  = reads(m1_rd, fd_rs1, fd_rs2) || reads(m2_rd, fd_rs1, fd_rs2) ||
                      reads(m3_rd, fd_rs1, fd_rs2);
  assign port_clash = fd_wr && (fd_op != OP_MUL) && (m1_rd != '0);
  assign waw        = fd_wr && dx_mul && (fd_rd == dx_rd);

  assign stall = ld_use || mul_use || mpipe_use || port_clash || waw;
  assign hold  = stall && !br_taken;

  assign pc_we     = !hold;
  assign fd_we     = !hold;
  assign fd_flush  = br_taken;
  assign dx_bubble = hold || br_taken;

  always_comb begin
    if (fwd_a == SEL_XM)
      p_fwda_src_r1: assert (dx_rs1 == xm_rd && dx_rs1 != '0)
        else $error("fwd_a selects X/M without a match");
    if (fwd_b == SEL_MW)
      p_fwdb_src_r2: assert (dx_rs2 == mw_rd && dx_rs2 != '0)
        else $error("fwd_b selects M/W without a match");
    if (dx_rs1 == '0)
      p_zero_reg_r3: assert (fwd_a == SEL_RF)
        else $error("register 0 forwarded");
    if (dx_op == OP_LD && dx_rd != '0 && fd_rs1 == dx_rd && !br_taken)
      p_load_use_r4: assert (!pc_we && !fd_we && dx_bubble && !fd_flush)
        else $error("load-use not stalled");
    if (fwd_sd)
      p_sd_match_r5: assert (mw_rd != '0 && xm_rs2 == mw_rd)
        else $error("store data forwarded without match");
    if (m3_rd != '0 && fd_rs2 == m3_rd && !br_taken)
      p_mul_pipe_r7: assert (!fd_we && !pc_we)
        else $error("multiplier latch hit not stalled");
    if (br_taken)
      p_flush_wins_r10: assert (fd_flush && dx_bubble && pc_we && fd_we)
        else $error("branch flush incomplete");
  end
endmodule

// File: tb/tb_hazard_ctl.sv
`timescale 1ns/1ps
module tb_hazard_ctl;
  localparam int RW = 5;
  localparam int OPW = 3;
  localparam logic [OPW-1:0] NOP = 3'd0, ALU = 3'd1, LD = 3'd2, ST = 3'd3, MUL = 3'd5;
  localparam logic [3:0] RUN = 4'b1100, STL = 4'b0001, FLS = 4'b1111;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [OPW-1:0] fd_op, dx_op, xm_op, mw_op;
  logic [RW-1:0] fd_rs1, fd_rs2, fd_rd, dx_rs1, dx_rs2, dx_rd, xm_rs2, xm_rd, mw_rd;
  logic [RW-1:0] m1_rd, m2_rd, m3_rd;
  logic br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic fwd_sd, pc_we, fd_we, fd_flush, dx_bubble;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  hazard_ctl #(.RW(RW), .OPW(OPW)) dut (
    .fd_op(fd_op), .fd_rs1(fd_rs1), .fd_rs2(fd_rs2), .fd_rd(fd_rd),
    .dx_op(dx_op), .dx_rs1(dx_rs1), .dx_rs2(dx_rs2), .dx_rd(dx_rd),
    .xm_op(xm_op), .xm_rs2(xm_rs2), .xm_rd(xm_rd), .mw_op(mw_op), .mw_rd(mw_rd),
    .m1_rd(m1_rd), .m2_rd(m2_rd), .m3_rd(m3_rd), .br_taken(br_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd), .pc_we(pc_we), .fd_we(fd_we),
    .fd_flush(fd_flush), .dx_bubble(dx_bubble));

  task automatic idle();
    @(posedge clk);
    fd_op = NOP; fd_rs1 = 0; fd_rs2 = 0; fd_rd = 0;
    dx_op = NOP; dx_rs1 = 0; dx_rs2 = 0; dx_rd = 0;
    xm_op = NOP; xm_rs2 = 0; xm_rd = 0; mw_op = NOP; mw_rd = 0;
    m1_rd = 0; m2_rd = 0; m3_rd = 0; br_taken = 0;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(string req, logic [3:0] exp);
    @(negedge clk);
    chk(req, {4'd0, pc_we, fd_we, fd_flush, dx_bubble}, {4'd0, exp});
  endtask

  task automatic sel(string req, logic [1:0] ea, logic [1:0] eb, logic esd);
    @(negedge clk);
    chk(req, {3'd0, fwd_a, fwd_b, fwd_sd}, {3'd0, ea, eb, esd});
  endtask

  task automatic t_quiet();
    idle(); sel("R11 idle selects", 2, 2, 0); ctl("R11 idle controls", RUN);
  endtask

  task automatic t_forward();
    idle(); dx_rs1 = 3; xm_op = ALU; xm_rd = 3; mw_op = ALU; mw_rd = 3;
    sel("R1 X/M beats M/W", 0, 2, 0);
    idle(); dx_rs1 = 3; mw_op = LD; mw_rd = 3; sel("R1 from M/W", 1, 2, 0);
    idle(); dx_rs2 = 4; xm_op = LD; xm_rd = 4; sel("R2 from X/M", 2, 0, 0);
    idle(); dx_rs2 = 4; mw_op = ALU; mw_rd = 4; dx_rs1 = 4; sel("R2 both from M/W", 1, 1, 0);
    idle(); dx_rs1 = 3; xm_op = ST; xm_rd = 3; sel("R3 store not producer", 2, 2, 0);
    idle(); xm_op = ALU; xm_rd = 0; mw_op = ALU; mw_rd = 0; sel("R3 register 0", 2, 2, 0);
  endtask

  task automatic t_load_use();
    idle(); dx_op = LD; dx_rd = 5; fd_op = ALU; fd_rs1 = 5; fd_rd = 6; ctl("R4 load-use rs1", STL);
    idle(); dx_op = LD; dx_rd = 5; fd_op = ALU; fd_rs2 = 5; fd_rd = 6; ctl("R4 load-use rs2", STL);
    idle(); dx_op = LD; dx_rd = 5; fd_op = ST; fd_rs1 = 1; fd_rs2 = 5; ctl("R4 store data exempt", RUN);
    idle(); dx_op = LD; dx_rd = 5; fd_op = ST; fd_rs1 = 5; ctl("R4 store address", STL);
    idle(); dx_op = LD; dx_rd = 0; fd_op = ALU; fd_rd = 6; ctl("R3 load to r0", RUN);
    idle(); dx_op = LD; dx_rd = 5; fd_op = ALU; fd_rs1 = 5; fd_rd = 6;
    dx_rs1 = 2; xm_op = ALU; xm_rd = 2; sel("R1 select kept during stall", 0, 2, 0);
  endtask

  task automatic t_store_data();
    idle(); xm_op = ST; xm_rs2 = 6; mw_op = LD; mw_rd = 6; sel("R5 store data fwd", 2, 2, 1);
    idle(); xm_op = ST; xm_rs2 = 6; mw_op = LD; mw_rd = 7; sel("R5 no match", 2, 2, 0);
    idle(); xm_op = ST; xm_rs2 = 6; mw_op = ST; mw_rd = 6; sel("R5 non-writer", 2, 2, 0);
    idle(); xm_op = ALU; xm_rs2 = 6; mw_op = ALU; mw_rd = 6; sel("R5 not a store", 2, 2, 0);
  endtask

  task automatic t_mul();
    idle(); dx_op = MUL; dx_rd = 8; fd_op = ST; fd_rs2 = 8; ctl("R6 mul feeds store data", STL);
    idle(); dx_op = MUL; dx_rd = 8; fd_op = ST; fd_rs1 = 8; ctl("R6 mul feeds address", STL);
    idle(); m1_rd = 9; fd_rs1 = 9; ctl("R7 first latch", STL);
    idle(); m2_rd = 9; fd_rs2 = 9; ctl("R7 second latch", STL);
    idle(); m3_rd = 9; fd_rs1 = 9; ctl("R7 third latch", STL);
    idle(); m3_rd = 9; fd_rs1 = 8; fd_rs2 = 7; ctl("R7 no match", RUN);
    idle(); m1_rd = 10; fd_op = ALU; fd_rd = 11; ctl("R8 port clash", STL);
    idle(); m1_rd = 10; fd_op = MUL; fd_rd = 11; ctl("R8 mul exempt", RUN);
    idle(); m1_rd = 10; fd_op = ALU; fd_rd = 0; ctl("R8 non-writer", RUN);
    idle(); m2_rd = 10; fd_op = LD; fd_rd = 11; ctl("R8 only first latch", RUN);
    idle(); dx_op = MUL; dx_rd = 12; fd_op = ALU; fd_rd = 12; ctl("R9 same dest", STL);
    idle(); dx_op = MUL; dx_rd = 12; fd_op = ALU; fd_rd = 13; ctl("R9 other dest", RUN);
    idle(); dx_op = ALU; dx_rd = 12; fd_op = ALU; fd_rd = 12; ctl("R9 not a mul", RUN);
  endtask

  task automatic t_flush();
    idle(); br_taken = 1; ctl("R10 flush alone", FLS);
    idle(); br_taken = 1; dx_op = LD; dx_rd = 5; fd_op = ALU; fd_rs1 = 5; fd_rd = 6;
    ctl("R10 flush beats stall", FLS);
    idle(); br_taken = 1; m1_rd = 10; fd_op = ALU; fd_rd = 11; ctl("R10 flush beats port clash", FLS);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_quiet();
    t_forward();
    t_load_use();
    t_store_data();
    t_mul();
    t_flush();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule